// File: doc/BRIEF.md
# Processor suspend request handshake

This block is the processor-side end of a suspend handshake. An external agent lowers an active-low suspend request. The controller samples that request on the rising clock edge. Once the request is allowed, it waits for the core to report that its instruction stream and the bus cycles tied to it have drained. It also waits for any PCI access that is in progress to finish. It then lowers an active-low acknowledge.

While the acknowledge is low, the controller stops internal clock groups. A depth select, captured on entry, chooses between two depths. In the shallow depth the display and memory controller clocks keep running. In the deep depth every clock derived from the system clock stops. PCI traffic keeps being serviced during the suspend. Non-maskable, maskable and system-management interrupt events that arrive during the suspend are each kept as one pending flag. The flags are replayed for one cycle after the acknowledge is released.

When the request returns high, the clocks are restored first and the acknowledge is then released. This normally takes two clocks, but it waits for a refresh cycle that is still running.

Top module: `susp_handshake`

## Requirements
- R1: The request is taken into a register on each rising edge. With enable, idle and no PCI access all present, the acknowledge falls at the second rising edge after the request is first low.
- R2: While `susp_en` is low, a low request never causes the acknowledge to fall.
- R3: While `core_idle` is low, the acknowledge stays high. It falls at the first edge at which `core_idle` is seen high with the request already sampled.
- R4: While `pci_busy` is high, entry is held off. It follows at the first edge with `pci_busy` low.
- R5: With no refresh active, the acknowledge rises at the second rising edge after the edge that samples the request high.
- R6: While `refresh_active` is high, release of the acknowledge is held off. It rises at the first edge with `refresh_active` low.
- R7: One edge after the acknowledge falls, `core_clk_en` goes low. `dm_clk_en` goes low as well only if `deep_sel` was high at the entry edge. `dm_clk_en` is never low while `core_clk_en` is high.
- R8: Clock enables change only on edges where the acknowledge is low both before and after the edge. Both enables are high again one edge before the acknowledge rises.
- R9: A high `pci_busy` during a suspend does not end it. The acknowledge stays low.
- R10: `pend_o` bit 0 holds NMI, bit 1 holds INTR and bit 2 holds SMI. A bit is set by its event input being high at any edge while the acknowledge is low. Repeats collapse into the one bit. Events seen while the acknowledge is high are not stored.
- R11: In the first cycle after the acknowledge rises, `replay_o` equals the pending flags. At the next edge, both `replay_o` and the flags clear. `replay_o` is zero at all other times.
- R12: Reset sets the acknowledge high, both clock enables high, and no flags pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| susp_req_n | input | 1 | Suspend request, active low |
| susp_en | input | 1 | Suspend handshake enable |
| deep_sel | input | 1 | Depth select: 1 stops all derived clocks |
| core_idle | input | 1 | Core instructions and their bus cycles have drained |
| pci_busy | input | 1 | A PCI access is in progress |
| refresh_active | input | 1 | A memory refresh cycle is running |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| intr_evt | input | 1 | Maskable interrupt event |
| smi_evt | input | 1 | System-management interrupt event |
| susp_ack_n | output | 1 | Suspend acknowledge, active low |
| core_clk_en | output | 1 | Core clock group enable |
| dm_clk_en | output | 1 | Display and memory controller clock enable |
| pend_o | output | N_IRQ | Pending interrupt flags {SMI, INTR, NMI} |
| replay_o | output | N_IRQ | One-cycle replay of pending flags after exit |

## Verification
A stuck or wrongly advanced sequencer state shows up at once on `susp_ack_n`: an early or missing fall, or a release that ignores refresh or the two-clock bound. A cycle-level reference model catches it within one edge. A wrong captured depth or a wrong gate-register update is visible on the clock enables one edge after entry or exit. A corrupted pending flag stays hidden while suspended only until `pend_o` is compared, which happens every cycle. Its effect on `replay_o` appears in the single cycle after release.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SUSP    = 2'd1,
    ST_RESTORE = 2'd2
  } susp_st_e;
endpackage

// File: rtl/susp_rst_sync.sv
module susp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shf_q <= '0;
    else         shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = shf_q[STAGES-1];
endmodule

// File: rtl/susp_seq.sv
module susp_seq
  import susp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_n,
  input  logic     en,
  input  logic     idle,
  input  logic     pci_busy,
  input  logic     refresh,
  output susp_st_e state_o,
  output logic     enter_o,
  output logic     hold_o
);
  logic     req_q;
  susp_st_e state_q, state_d;

  // request sampled on the rising edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= ~req_n;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (req_q && en && idle && !pci_busy) state_d = ST_SUSP;
      ST_SUSP:    if (!req_q)                           state_d = ST_RESTORE;
      ST_RESTORE: if (!refresh)                         state_d = ST_RUN;
      default:                                          state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign enter_o = (state_q == ST_RUN)  && (state_d == ST_SUSP);
  assign hold_o  = (state_q == ST_SUSP) && (state_d == ST_SUSP);
endmodule

// File: rtl/susp_clk_gate.sv
module susp_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_sel,
  input  logic enter,
  input  logic hold,
  output logic core_en_o,
  output logic dm_en_o
);
  logic deep_q;
  logic core_q, core_d;
  logic dm_q, dm_d;

  // depth captured once, on the entry edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     deep_q <= 1'b0;
    else if (enter) deep_q <= deep_sel;
  end

  always_comb begin
    core_d = ~hold;
    dm_d   = ~(hold & deep_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b1;
      dm_q   <= 1'b1;
    end else begin
      core_q <= core_d;
      dm_q   <= dm_d;
    end
  end

  assign core_en_o = core_q;
  assign dm_en_o   = dm_q;
endmodule

// File: rtl/susp_irq_hold.sv
module susp_irq_hold #(
  parameter int N_IRQ = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspended,
  input  logic [N_IRQ-1:0] evt,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] replay_o
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      if (suspended) flag_d = flag_q | evt[i];
      else           flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign pend_o[i]   = flag_q;
    assign replay_o[i] = flag_q & ~suspended;
  end
endmodule

// File: rtl/susp_handshake.sv
module susp_handshake
  import susp_pkg::*;
#(
  parameter int N_IRQ       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             susp_req_n,
  input  logic             susp_en,
  input  logic             deep_sel,
  input  logic             core_idle,
  input  logic             pci_busy,
  input  logic             refresh_active,
  input  logic             nmi_evt,
  input  logic             intr_evt,
  input  logic             smi_evt,
  output logic             susp_ack_n,
  output logic             core_clk_en,
  output logic             dm_clk_en,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] replay_o
);
  localparam int N_EVT = 3;

  logic             rst_int_n;
  susp_st_e         state;
  logic             enter, hold;
  logic [N_IRQ-1:0] evt_vec;

  always_comb begin
    evt_vec = '0;
    evt_vec[N_EVT-1:0] = {smi_evt, intr_evt, nmi_evt};
  end

  susp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  susp_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .req_n(susp_req_n), .en(susp_en),
    .idle(core_idle), .pci_busy(pci_busy), .refresh(refresh_active),
    .state_o(state), .enter_o(enter), .hold_o(hold)
  );

  susp_clk_gate u_gate (
    .clk(clk), .rst_n(rst_int_n), .deep_sel(deep_sel), .enter(enter),
    .hold(hold), .core_en_o(core_clk_en), .dm_en_o(dm_clk_en)
  );

  susp_irq_hold #(.N_IRQ(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .suspended(state != ST_RUN),
    .evt(evt_vec), .pend_o(pend_o), .replay_o(replay_o)
  );

  assign susp_ack_n = (state == ST_RUN);
endmodule

// File: rtl/susp_handshake_chk.sv
module susp_handshake_chk #(
  parameter int N_IRQ = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             susp_en,
  input logic             core_idle,
  input logic             pci_busy,
  input logic             refresh_active,
  input logic             susp_ack_n,
  input logic             core_clk_en,
  input logic             dm_clk_en,
  input logic [N_IRQ-1:0] pend_o,
  input logic [N_IRQ-1:0] replay_o
);
  // R2, R3, R4: entry only when enabled, drained and no PCI access
  a_r4_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_ack_n) |-> ($past(susp_en) && $past(core_idle) && !$past(pci_busy)));

  // R6: release never during refresh
  a_r6_release_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_ack_n) |-> !$past(refresh_active));

  // R7: display/memory group off implies core group off
  a_r7_depth_order: assert property (@(posedge clk) disable iff (!rst_n)
    !dm_clk_en |-> !core_clk_en);

  // R8: gate changes confined to acknowledged window
  a_r8_core_gate_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_clk_en) |-> (!susp_ack_n && !$past(susp_ack_n)));
  a_r8_dm_gate_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dm_clk_en) |-> (!susp_ack_n && !$past(susp_ack_n)));
  a_r8_restored_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_ack_n) |-> (core_clk_en && dm_clk_en));

  // R10: flags only set while acknowledged
  a_r10_set_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(pend_o)) != '0) |-> !$past(susp_ack_n));

  // R11: replay only outside suspend, and it clears the flags
  a_r11_replay_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_o) |-> susp_ack_n);
  a_r11_replay_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|replay_o) |=> ((pend_o & $past(replay_o)) == '0));
endmodule

bind susp_handshake susp_handshake_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .susp_en(susp_en), .core_idle(core_idle),
  .pci_busy(pci_busy), .refresh_active(refresh_active),
  .susp_ack_n(susp_ack_n), .core_clk_en(core_clk_en), .dm_clk_en(dm_clk_en),
  .pend_o(pend_o), .replay_o(replay_o)
);

// File: tb/susp_handshake_test.sv
module susp_handshake_test;
  localparam int N_IRQ = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic susp_req_n = 1'b1, susp_en = 1'b1, deep_sel = 1'b0, core_idle = 1'b1;
  logic pci_busy = 1'b0, refresh_active = 1'b0;
  logic nmi_evt = 1'b0, intr_evt = 1'b0, smi_evt = 1'b0;
  logic susp_ack_n, core_clk_en, dm_clk_en;
  logic [N_IRQ-1:0] pend_o, replay_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur = "R12";

  always #10 clk = ~clk; // 50 MHz

  susp_handshake #(.N_IRQ(N_IRQ)) uut (.*);

  // reference model built from the requirements
  logic mr1 = 1'b0, mr2 = 1'b0, m_req = 1'b0, m_deep = 1'b0;
  logic m_core = 1'b1, m_dm = 1'b1;
  int m_st = 0; // 0 run, 1 suspended, 2 restoring
  logic [2:0] m_pend = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 1'b0; mr2 <= 1'b0;
      m_req <= 1'b0; m_st <= 0; m_deep <= 1'b0;
      m_core <= 1'b1; m_dm <= 1'b1; m_pend <= '0;
    end else begin
      mr1 <= 1'b1; mr2 <= mr1;
      if (mr2) begin
        m_req <= ~susp_req_n;
        m_core <= !(m_st == 1 && m_req);
        m_dm <= !(m_st == 1 && m_req && m_deep);
        if (m_st == 0) m_pend <= '0;
        else m_pend <= m_pend | {smi_evt, intr_evt, nmi_evt};
        case (m_st)
          0: if (m_req && susp_en && core_idle && !pci_busy) begin
               m_st <= 1; m_deep <= deep_sel;
             end
          1: if (!m_req) m_st <= 2;
          default: if (!refresh_active) m_st <= 0;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk({cur, " model"},
        {23'd0, susp_ack_n, core_clk_en, dm_clk_en, pend_o, replay_o},
        {23'd0, (m_st == 0), m_core, m_dm, m_pend,
         ((m_st == 0) ? m_pend : 3'b000)});
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1e5c_0b7d));
    step(3); rst_n = 1'b1; step(4);
    chk("R12 reset", {susp_ack_n, core_clk_en, dm_clk_en, pend_o}, 6'b111000);

    cur = "R2"; susp_en = 1'b0; susp_req_n = 1'b0; step(8);
    chk("R2 disabled", susp_ack_n, 1);
    susp_req_n = 1'b1; susp_en = 1'b1; step(3);

    cur = "R3"; core_idle = 1'b0; susp_req_n = 1'b0; deep_sel = 1'b1; step(6);
    chk("R3 busy core", susp_ack_n, 1);
    core_idle = 1'b1; step(1);
    chk("R3 drained", susp_ack_n, 0);
    deep_sel = 1'b0; step(1);
    chk("R7 deep gates", {core_clk_en, dm_clk_en}, 2'b00);

    cur = "R9"; pci_busy = 1'b1; step(5);
    chk("R9 pci in suspend", susp_ack_n, 0);
    pci_busy = 1'b0;

    cur = "R10"; nmi_evt = 1'b1; step(1); nmi_evt = 1'b0; step(2);
    nmi_evt = 1'b1; intr_evt = 1'b1; step(1); nmi_evt = 1'b0; intr_evt = 1'b0; step(1);
    chk("R10 collapse", pend_o, 3'b011);

    cur = "R5"; susp_req_n = 1'b1; step(1);
    chk("R5 one edge", susp_ack_n, 0);
    step(1);
    chk("R8 restore first", {susp_ack_n, core_clk_en, dm_clk_en}, 3'b011);
    step(1);
    chk("R5 two edges", susp_ack_n, 1);
    chk("R11 replay", replay_o, 3'b011);
    smi_evt = 1'b1; step(1); smi_evt = 1'b0;
    chk("R11 cleared", {pend_o, replay_o}, 6'b0);
    step(1);
    chk("R10 ignored in run", pend_o, 3'b000);

    cur = "R4"; pci_busy = 1'b1; susp_req_n = 1'b0; step(5);
    chk("R4 held off", susp_ack_n, 1);
    pci_busy = 1'b0; step(1);
    chk("R4 entered", susp_ack_n, 0);
    step(1);
    chk("R7 shallow gates", {core_clk_en, dm_clk_en}, 2'b01);

    cur = "R6"; refresh_active = 1'b1; susp_req_n = 1'b1; step(5);
    chk("R6 stretched", susp_ack_n, 0);
    refresh_active = 1'b0; step(1);
    chk("R6 released", susp_ack_n, 1);

    cur = "R1"; step(2); susp_req_n = 1'b0; step(1);
    chk("R1 first edge", susp_ack_n, 1);
    step(1);
    chk("R1 second edge", susp_ack_n, 0);
    susp_req_n = 1'b1; step(4);

    cur = "R1 R7 R10 random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) begin
        susp_req_n = ~susp_req_n;
        deep_sel = $urandom_range(1);
      end
      if ($urandom_range(31) == 0) susp_en = ~susp_en;
      core_idle = ($urandom_range(3) != 0);
      pci_busy = ($urandom_range(4) == 0);
      refresh_active = ($urandom_range(2) == 0);
      nmi_evt = ($urandom_range(9) == 0);
      intr_evt = ($urandom_range(9) == 0);
      smi_evt = ($urandom_range(9) == 0);
      step(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule